// File: doc/BRIEF.md
# Pixel Location Coordinate Recorder

This block watches a raster stream of grey values and records where pixels of interest sit. Two position counters follow the raster: one for the column and one for the row. Each counter has its own count-enable and clear inputs, and the counters are driven by whatever line and frame timing surrounds the block. A 512-entry lookup table, loaded through a simple write port, marks each grey level as interesting or not. Each marked grey level also carries a 6-bit group code, so that several classes of pixel can be told apart.

When a valid pixel arrives whose grey level is marked, the block packs the current column, the current row and the group code into one 24-bit record. It writes the record into a 512-entry record memory at the slot held by a find-pixel pointer, then advances the pointer. When the pointer passes the last slot it wraps to zero and overwrites the oldest records, and a sticky flag tells software this has happened.

A dedicated pointer-clear input empties the record store and restarts the pointer. A combinational read port returns any record by index. Slots that have not been written since the last clear read as zero.

Top module: `pixloc_recorder`

## Requirements
- R1: The column counter `col_pos` (9 bits) increments by one, modulo 512, on each clock edge where `col_inc` is 1. `col_clr` forces it to 0 and overrides `col_inc`.
- R2: The row counter `row_pos` (9 bits) increments by one, modulo 512, on each clock edge where `row_inc` is 1. `row_clr` forces it to 0 and overrides `row_inc`.
- R3: A clock edge with `tbl_we` = 1 writes `tbl_wdata` into table entry `tbl_waddr`. In an entry, bits 5:0 are the group code, bits 7:6 are ignored and bit 8 is the mark bit. The new entry applies to pixels from the following edge onward.
- R4: A record is stored only on an edge where `pix_valid` = 1 and the entry addressed by `grey` has its mark bit set. Otherwise the pointer and the record memory are unchanged.
- R5: A record holds the column in bits 8:0, the row in bits 17:9 and the group code in bits 23:18. The column and row are the counter values present in the storing cycle, before that edge's own increments.
- R6: A record is written at slot `fp_ptr`, and `fp_ptr` reads one higher after the storing edge.
- R7: A store at slot 511 wraps `fp_ptr` to 0, and later stores overwrite slots from 0 upward.
- R8: `wrapped` goes to 1 on the edge that wraps the pointer from 511 to 0 and stays 1 until `fp_clr` or reset.
- R9: `fp_clr` = 1 sets `fp_ptr` to 0 and `wrapped` to 0, and makes every slot read zero. A store requested on the same edge is discarded.
- R10: `rd_data` shows the record in slot `rd_addr` in the same cycle. A slot not written since the last clear or reset reads 0.
- R11: An active-low `rst_n` asynchronously clears both counters, the pointer, `wrapped`, all table entries (leaving every grey level unmarked) and the record store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_inc | input | 1 | Column counter enable |
| col_clr | input | 1 | Column counter clear, overrides enable |
| row_inc | input | 1 | Row counter enable |
| row_clr | input | 1 | Row counter clear, overrides enable |
| pix_valid | input | 1 | Current grey value is a valid pixel |
| grey | input | 9 | Current grey value, indexes the table |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 9 | Table entry to write |
| tbl_wdata | input | 9 | Table entry value: mark bit 8, group code 5:0 |
| fp_clr | input | 1 | Pointer and record store clear |
| rd_addr | input | 9 | Record read index |
| rd_data | output | 24 | Record at rd_addr, zero if empty |
| fp_ptr | output | 9 | Find-pixel pointer, next slot to write |
| col_pos | output | 9 | Current column count |
| row_pos | output | 9 | Current row count |
| wrapped | output | 1 | Sticky pointer rollover flag |

## Verification
A wrong pointer shows at once: `fp_ptr` is a port, so a skipped or doubled advance is visible one edge after the pixel that caused it. A record written to the wrong slot, or packed in the wrong field order, only shows when that slot is read back. The bench therefore reads each new record in the cycle after its edge. A lost rollover or a stale valid bit after a clear stays hidden until slot 0 is read or `wrapped` is sampled, so the wrap and clear tests read both right after the event.

// File: rtl/pixloc_recorder.sv
module pixloc_recorder #(
  parameter int PW = 9,
  parameter int GW = 9,
  parameter int FW = 6,
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          col_inc,
  input  logic          col_clr,
  input  logic          row_inc,
  input  logic          row_clr,
  input  logic          pix_valid,
  input  logic [GW-1:0] grey,
  input  logic          tbl_we,
  input  logic [GW-1:0] tbl_waddr,
  input  logic [LW-1:0] tbl_wdata,
  input  logic          fp_clr,
  input  logic [PW-1:0] rd_addr,
  output logic [2*PW+FW-1:0] rd_data,
  output logic [PW-1:0] fp_ptr,
  output logic [PW-1:0] col_pos,
  output logic [PW-1:0] row_pos,
  output logic          wrapped
);
  localparam int TBL_N = 1 << GW;
  localparam int DEPTH = 1 << PW;
  localparam int RW    = 2 * PW + FW;
  localparam int MARK  = LW - 1;

  logic [LW-1:0]    tbl  [TBL_N];
  logic [RW-1:0]    recs [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [LW-1:0]    entry;
  logic             hit;

  assign entry = tbl[grey];
  assign hit   = pix_valid && entry[MARK] && !fp_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_pos <= '0;
      row_pos <= '0;
    end else begin
      if (col_clr)      col_pos <= '0;
      else if (col_inc) col_pos <= col_pos + 1'b1;
      if (row_clr)      row_pos <= '0;
      else if (row_inc) row_pos <= row_pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_N; i++) tbl[i] <= '0;
    end else if (tbl_we) begin
      tbl[tbl_waddr] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_ptr  <= '0;
      wrapped <= 1'b0;
      filled  <= '0;
    end else if (fp_clr) begin
      fp_ptr  <= '0;
      wrapped <= 1'b0;
      filled  <= '0;
    end else if (hit) begin
      fp_ptr         <= fp_ptr + 1'b1;
      filled[fp_ptr] <= 1'b1;
      if (&fp_ptr) wrapped <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (hit) recs[fp_ptr] <= {entry[FW-1:0], row_pos, col_pos};
  end

  assign rd_data = filled[rd_addr] ? recs[rd_addr] : '0;

endmodule

module pixloc_recorder_chk #(
  parameter int PW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          col_inc,
  input logic          col_clr,
  input logic          row_inc,
  input logic          row_clr,
  input logic          fp_clr,
  input logic [PW-1:0] fp_ptr,
  input logic [PW-1:0] col_pos,
  input logic [PW-1:0] row_pos,
  input logic          wrapped
);
  // R1
  col_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_clr |=> col_pos == '0);
  // R1
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_clr && col_inc) |=> col_pos == $past(col_pos) + 1'b1);
  // R2
  row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_clr |=> row_pos == '0);
  // R2
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_clr && !row_inc) |=> $stable(row_pos));
  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_clr |=> (fp_ptr == $past(fp_ptr) || fp_ptr == $past(fp_ptr) + 1'b1));
  // R9
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_clr |=> (fp_ptr == '0 && !wrapped));
  // R8
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !fp_clr) |=> wrapped);
  // R8
  wrap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapped) |-> (fp_ptr == '0 && $past(&fp_ptr)));
endmodule

bind pixloc_recorder pixloc_recorder_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .col_inc(col_inc), .col_clr(col_clr),
  .row_inc(row_inc), .row_clr(row_clr), .fp_clr(fp_clr), .fp_ptr(fp_ptr),
  .col_pos(col_pos), .row_pos(row_pos), .wrapped(wrapped)
);

// File: tb/pixloc_recorder_tb.sv
`timescale 1ns/100ps
module pixloc_recorder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        col_inc = 0, col_clr = 0, row_inc = 0, row_clr = 0;
  logic        pix_valid = 0, tbl_we = 0, fp_clr = 0;
  logic [8:0]  grey = '0, tbl_waddr = '0, tbl_wdata = '0, rd_addr = '0;
  logic [23:0] rd_data;
  logic [8:0]  fp_ptr, col_pos, row_pos;
  logic        wrapped;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pixloc_recorder dut_i (
    .clk(clk), .rst_n(rst_n), .col_inc(col_inc), .col_clr(col_clr),
    .row_inc(row_inc), .row_clr(row_clr), .pix_valid(pix_valid), .grey(grey),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .fp_clr(fp_clr), .rd_addr(rd_addr), .rd_data(rd_data), .fp_ptr(fp_ptr),
    .col_pos(col_pos), .row_pos(row_pos), .wrapped(wrapped)
  );

  // grey, valid, col_inc, row_inc, store, exp col, exp row, exp flag, exp ptr after
  typedef struct packed {
    logic [8:0] g; logic v; logic ci; logic ri; logic st;
    logic [8:0] ex; logic [8:0] ey; logic [5:0] ef; logic [8:0] ep;
  } vec_t;
  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{9'd5,   1'b1, 1'b1, 1'b0, 1'b1, 9'd0, 9'd0, 6'h2A, 9'd1},
    '{9'd5,   1'b0, 1'b1, 1'b0, 1'b0, 9'd0, 9'd0, 6'h00, 9'd1},
    '{9'd9,   1'b1, 1'b1, 1'b0, 1'b0, 9'd0, 9'd0, 6'h00, 9'd1},
    '{9'd7,   1'b1, 1'b0, 1'b1, 1'b1, 9'd3, 9'd0, 6'h03, 9'd2},
    '{9'd12,  1'b1, 1'b1, 1'b0, 1'b1, 9'd3, 9'd1, 6'h15, 9'd3},
    '{9'd100, 1'b1, 1'b0, 1'b0, 1'b0, 9'd0, 9'd0, 6'h00, 9'd3},
    '{9'd7,   1'b1, 1'b1, 1'b1, 1'b1, 9'd4, 9'd1, 6'h03, 9'd4}
  };

  function automatic logic [23:0] rec(input logic [8:0] x, input logic [8:0] y, input logic [5:0] f);
    return {f, y, x};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic read_chk(input string req, input logic [8:0] a, input logic [23:0] exp);
    rd_addr = a;
    #0.5;
    chk(req, rd_data, exp);
  endtask

  task automatic tbl_put(input logic [8:0] a, input logic [8:0] d);
    tbl_we = 1; tbl_waddr = a; tbl_wdata = d;
    tick();
    tbl_we = 0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #5 rst_n = 1;
    #0.5;
    // R11 reset state
    chk("R11 ptr", fp_ptr, 0);
    chk("R11 wrapped", wrapped, 0);
    chk("R11 col/row", {col_pos, row_pos}, 0);
    read_chk("R10 empty slot", 9'd0, 24'h0);
    // R11 table cleared: marked nothing, so a valid pixel stores nothing
    pix_valid = 1; grey = 9'd5; tick(); pix_valid = 0;
    chk("R11 table unmarked", fp_ptr, 0);

    // R3 table loads; bits 7:6 of entry for grey 12 are set and must be ignored
    tbl_put(9'd5,  9'h12A);
    tbl_put(9'd7,  9'h103);
    tbl_put(9'd9,  9'h0C1);
    tbl_put(9'd12, 9'h1D5);

    for (int i = 0; i < NV; i++) begin
      grey = VECS[i].g; pix_valid = VECS[i].v;
      col_inc = VECS[i].ci; row_inc = VECS[i].ri;
      tick();
      pix_valid = 0; col_inc = 0; row_inc = 0;
      chk("R6 ptr advance", fp_ptr, VECS[i].ep);
      if (VECS[i].st)
        read_chk("R5 record", VECS[i].ep - 9'd1, rec(VECS[i].ex, VECS[i].ey, VECS[i].ef));
      else
        read_chk("R4 no store", VECS[i].ep, 24'h0);
    end
    chk("R1 col after table", col_pos, 5);
    chk("R2 row after table", row_pos, 2);

    // R1 clear overrides increment
    col_inc = 1; col_clr = 1; tick(); col_inc = 0; col_clr = 0;
    chk("R1 clr priority", col_pos, 0);
    // R2 clear overrides increment
    row_inc = 1; row_clr = 1; tick(); row_inc = 0; row_clr = 0;
    chk("R2 clr priority", row_pos, 0);

    // R3 write lands next edge: unmark grey 5 then present it
    tbl_put(9'd5, 9'h02A);
    pix_valid = 1; grey = 9'd5; tick(); pix_valid = 0;
    chk("R3 unmarked entry", fp_ptr, 4);
    tbl_put(9'd5, 9'h12A);

    // R9 clear with a simultaneous marked pixel
    fp_clr = 1; pix_valid = 1; grey = 9'd7; tick(); fp_clr = 0; pix_valid = 0;
    chk("R9 ptr zero", fp_ptr, 0);
    read_chk("R9 slot0 empty", 9'd0, 24'h0);
    read_chk("R9 slot3 empty", 9'd3, 24'h0);

    // R7 / R8 fill all 512 slots at column 0, row 0
    pix_valid = 1; grey = 9'd5;
    for (int k = 0; k < 511; k++) tick();
    pix_valid = 0;
    chk("R8 no wrap yet", wrapped, 0);
    chk("R6 ptr 511", fp_ptr, 511);
    pix_valid = 1; tick(); pix_valid = 0;
    chk("R7 ptr wraps", fp_ptr, 0);
    chk("R8 wrap set", wrapped, 1);
    for (int k = 0; k < 7; k++) begin col_inc = 1; tick(); end
    col_inc = 0;
    pix_valid = 1; grey = 9'd7; tick(); pix_valid = 0;
    read_chk("R7 overwrite slot0", 9'd0, rec(9'd7, 9'd0, 6'h03));
    read_chk("R7 slot1 old", 9'd1, rec(9'd0, 9'd0, 6'h2A));
    read_chk("R10 slot511", 9'd511, rec(9'd0, 9'd0, 6'h2A));
    chk("R8 sticky", wrapped, 1);
    fp_clr = 1; tick(); fp_clr = 0;
    chk("R8 cleared", wrapped, 0);
    read_chk("R9 slot1 empty", 9'd1, 24'h0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule